// File: doc/BRIEF.md
# Indexed Display Register Port Decoder

This block sits on a byte-wide I/O bus of a display controller and decodes a 16-bit port address into three indexed register groups (sequencer, graphics and CRT controller) plus one stand-alone miscellaneous output register. Each group is reached through a pair of ports. A write to the index port selects a register. A following access to the data port reads or writes that register. The stored index can always be read back.

The miscellaneous output register is written at one address and read back at another. The address where it is written returns an external input status byte on reads. In the CRT controller group, one protect bit guards the low registers against CPU writes, except for a single field that stays writable. Reads are combinational from the registered state. Writes take effect at the rising clock edge on which the write strobe is high.

Top module: `disp_reg_decoder`

## Requirements
- R1: The ports are: sequencer index 3C4h and data 3C5h; graphics index 3CEh and data 3CFh; CRT controller index 3D4h and data 3D5h. A data-port access reads or writes the register selected by that group's stored index.
- R2: A read of an index port returns the stored index. The index changes only on a write to that index port. Index bits above the group's index width (3 bits for the sequencer, 4 for graphics, 5 for the CRT controller) are dropped on write and read back as zero.
- R3: The miscellaneous output register is written at 3C2h and read at 3CCh. A write to 3CCh changes nothing.
- R4: A read of 3C2h returns the `status_in` byte, not the miscellaneous output register.
- R5: A data read at an index at or above the group's register count (5, 9 and 25) returns 00h. A data write there changes no register.
- R6: While bit 7 of CRT register 11h is 1, writes to CRT registers 00h–06h are ignored. A write to CRT 07h then changes only bit 4.
- R7: CRT register 11h is always writable, so clearing bit 7 lifts the protection for the writes that follow.
- R8: A synchronous reset clears every index and register to 00h.
- R9: `io_rdata` is 00h when `io_rd` is low or the address is not one of the mapped ports. Writes to unmapped addresses change no state.
- R10: `misc_out` always shows the current miscellaneous output register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe, one byte per cycle |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| status_in | input | 8 | Input status byte returned at 3C2h |
| io_rdata | output | 8 | Read data, valid while io_rd is high |
| misc_out | output | 8 | Miscellaneous output register value |

## Verification
The bench builds the block with its default counts: 5 sequencer, 9 graphics and 25 CRT controller registers. The sequencer's 3-bit index then has three unimplemented codes, and the graphics and CRT fields have seven each. Random index writes therefore reach the zero-read and ignored-write path often. A count of 25 places CRT index 11h inside the array, so random writes to it switch the protect bit on and off. Ordinary random traffic thus mixes protected and unprotected writes to indices 00h–07h, including the partially writable 07h.

// File: rtl/disp_reg_pkg.sv
package disp_reg_pkg;

    localparam logic [15:0] PORT_MISC_WR = 16'h03C2;
    localparam logic [15:0] PORT_MISC_RD = 16'h03CC;
    localparam logic [15:0] PORT_SEQ_IDX = 16'h03C4;
    localparam logic [15:0] PORT_SEQ_DAT = 16'h03C5;
    localparam logic [15:0] PORT_GFX_IDX = 16'h03CE;
    localparam logic [15:0] PORT_GFX_DAT = 16'h03CF;
    localparam logic [15:0] PORT_CRT_IDX = 16'h03D4;
    localparam logic [15:0] PORT_CRT_DAT = 16'h03D5;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_SEQ_IDX,
        SEL_SEQ_DAT,
        SEL_GFX_IDX,
        SEL_GFX_DAT,
        SEL_CRT_IDX,
        SEL_CRT_DAT,
        SEL_MISC_WR,
        SEL_MISC_RD
    } port_sel_e;

endpackage

// File: rtl/disp_port_decode.sv
module disp_port_decode
    import disp_reg_pkg::*;
(
    input  logic [15:0] addr,
    output port_sel_e   sel
);

    always_comb begin
        unique case (addr)
            PORT_SEQ_IDX: sel = SEL_SEQ_IDX;
            PORT_SEQ_DAT: sel = SEL_SEQ_DAT;
            PORT_GFX_IDX: sel = SEL_GFX_IDX;
            PORT_GFX_DAT: sel = SEL_GFX_DAT;
            PORT_CRT_IDX: sel = SEL_CRT_IDX;
            PORT_CRT_DAT: sel = SEL_CRT_DAT;
            PORT_MISC_WR: sel = SEL_MISC_WR;
            PORT_MISC_RD: sel = SEL_MISC_RD;
            default:      sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/disp_reg_group.sv
module disp_reg_group #(
    parameter int          NREG       = 5,
    parameter bit          PROT_EN    = 1'b0,
    parameter int          PROT_REG   = 17,
    parameter int          PROT_BIT   = 7,
    parameter int          PROT_LAST  = 7,
    parameter logic [7:0]  PROT_KEEP  = 8'h10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_wr,
    input  logic       dat_wr,
    input  logic [7:0] wdata,
    output logic [7:0] idx_rd,
    output logic [7:0] dat_rd
);

    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    typedef struct packed {
        logic [IDX_W-1:0]     idx;
        logic [NREG-1:0][7:0] regs;
    } grp_state_t;

    grp_state_t st_d, st_q;
    logic       hit;
    logic       prot_on;
    logic       prot_hit;
    logic [7:0] cur_val;

    generate
        if (PROT_EN) begin : g_prot
            assign prot_on = st_q.regs[PROT_REG][PROT_BIT];
        end else begin : g_noprot
            assign prot_on = 1'b0;
        end
    endgenerate

    assign hit      = (32'(st_q.idx) < 32'(NREG));
    assign cur_val  = hit ? st_q.regs[st_q.idx] : 8'h00;
    assign prot_hit = prot_on && (32'(st_q.idx) <= 32'(PROT_LAST));

    always_comb begin
        st_d = st_q;
        if (idx_wr) begin
            st_d.idx = wdata[IDX_W-1:0];
        end
        if (dat_wr && hit) begin
            if (!prot_hit) begin
                st_d.regs[st_q.idx] = wdata;
            end else if (32'(st_q.idx) == 32'(PROT_LAST)) begin
                st_d.regs[st_q.idx] = (cur_val & ~PROT_KEEP) | (wdata & PROT_KEEP);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign idx_rd = {{(8 - IDX_W){1'b0}}, st_q.idx};
    assign dat_rd = cur_val;

    // R2: index holds unless its port is written
    a_r2_idx_hold: assert property (@(posedge clk) disable iff (rst)
        !idx_wr |=> $stable(st_q.idx));

    // R5: data writes beyond the register count leave the array untouched
    a_r5_unimpl_ignore: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && !hit) |=> $stable(st_q.regs));

    // R8: reset clears the whole state
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (st_q == '0));

    generate
        if (PROT_EN) begin : g_prot_chk
            // R6: fully guarded registers keep their value
            a_r6_prot_block: assert property (@(posedge clk) disable iff (rst)
                (dat_wr && prot_on && 32'(st_q.idx) < 32'(PROT_LAST)) |=> $stable(st_q.regs));
            // R6: in the last guarded register only the keep bits may move
            a_r6_prot_keep: assert property (@(posedge clk) disable iff (rst)
                (dat_wr && prot_on && 32'(st_q.idx) == 32'(PROT_LAST))
                |=> ((st_q.regs[PROT_LAST] & ~PROT_KEEP) ==
                     $past(st_q.regs[PROT_LAST] & ~PROT_KEEP)));
        end
    endgenerate

endmodule

// File: rtl/disp_reg_decoder.sv
module disp_reg_decoder
    import disp_reg_pkg::*;
#(
    parameter int SEQ_REGS = 5,
    parameter int GFX_REGS = 9,
    parameter int CRT_REGS = 25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  io_wdata,
    input  logic [7:0]  status_in,
    output logic [7:0]  io_rdata,
    output logic [7:0]  misc_out
);

    localparam int NGRP = 3;

    typedef struct packed {
        logic [7:0] misc;
    } top_state_t;

    port_sel_e  sel;
    top_state_t st_d, st_q;
    logic [NGRP-1:0]      g_idx_wr, g_dat_wr;
    logic [NGRP-1:0][7:0] g_idx_rd, g_dat_rd;
    logic [7:0]           rd_mux;

    disp_port_decode i_dec (.addr(io_addr), .sel(sel));

    assign g_idx_wr[0] = io_wr && (sel == SEL_SEQ_IDX);
    assign g_dat_wr[0] = io_wr && (sel == SEL_SEQ_DAT);
    assign g_idx_wr[1] = io_wr && (sel == SEL_GFX_IDX);
    assign g_dat_wr[1] = io_wr && (sel == SEL_GFX_DAT);
    assign g_idx_wr[2] = io_wr && (sel == SEL_CRT_IDX);
    assign g_dat_wr[2] = io_wr && (sel == SEL_CRT_DAT);

    disp_reg_group #(.NREG(SEQ_REGS), .PROT_EN(1'b0)) i_seq (
        .clk(clk), .rst(rst), .idx_wr(g_idx_wr[0]), .dat_wr(g_dat_wr[0]),
        .wdata(io_wdata), .idx_rd(g_idx_rd[0]), .dat_rd(g_dat_rd[0]));

    disp_reg_group #(.NREG(GFX_REGS), .PROT_EN(1'b0)) i_gfx (
        .clk(clk), .rst(rst), .idx_wr(g_idx_wr[1]), .dat_wr(g_dat_wr[1]),
        .wdata(io_wdata), .idx_rd(g_idx_rd[1]), .dat_rd(g_dat_rd[1]));

    disp_reg_group #(.NREG(CRT_REGS), .PROT_EN(1'b1), .PROT_REG(17), .PROT_BIT(7),
                     .PROT_LAST(7), .PROT_KEEP(8'h10)) i_crt (
        .clk(clk), .rst(rst), .idx_wr(g_idx_wr[2]), .dat_wr(g_dat_wr[2]),
        .wdata(io_wdata), .idx_rd(g_idx_rd[2]), .dat_rd(g_dat_rd[2]));

    always_comb begin
        st_d = st_q;
        if (io_wr && sel == SEL_MISC_WR) st_d.misc = io_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        unique case (sel)
            SEL_SEQ_IDX: rd_mux = g_idx_rd[0];
            SEL_SEQ_DAT: rd_mux = g_dat_rd[0];
            SEL_GFX_IDX: rd_mux = g_idx_rd[1];
            SEL_GFX_DAT: rd_mux = g_dat_rd[1];
            SEL_CRT_IDX: rd_mux = g_idx_rd[2];
            SEL_CRT_DAT: rd_mux = g_dat_rd[2];
            SEL_MISC_WR: rd_mux = status_in;
            SEL_MISC_RD: rd_mux = st_q.misc;
            default:     rd_mux = 8'h00;
        endcase
    end

    assign io_rdata = io_rd ? rd_mux : 8'h00;
    assign misc_out = st_q.misc;

    // R3: misc register moves only on a write at its write port
    a_r3_misc_hold: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && io_addr == PORT_MISC_WR) |=> $stable(misc_out));

    // R4: reads at the misc write port return the status input
    a_r4_status_read: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_addr == PORT_MISC_WR) |-> (io_rdata == status_in));

    // R10: a misc write is visible on misc_out next cycle
    a_r10_misc_follow: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == PORT_MISC_WR) |=> (misc_out == $past(io_wdata)));

    // R9: at most one group index strobe at a time
    a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({g_idx_wr, g_dat_wr}));

endmodule

// File: tb/test_disp_reg_decoder.sv
module test_disp_reg_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int SEQ_N = 5;
    localparam int GFX_N = 9;
    localparam int CRT_N = 25;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] io_addr;
    logic        io_wr, io_rd;
    logic [7:0]  io_wdata, status_in;
    logic [7:0]  io_rdata, misc_out;

    int total = 0;
    int bad   = 0;

    logic [7:0] m_seq [8];
    logic [7:0] m_gfx [16];
    logic [7:0] m_crt [32];
    logic [7:0] m_si, m_gi, m_ci, m_misc;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_reg_decoder i_disp_reg_decoder (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .status_in(status_in), .io_rdata(io_rdata),
        .misc_out(misc_out));

    task automatic model_reset();
        for (int i = 0; i < 8; i++)  m_seq[i] = 8'h00;
        for (int i = 0; i < 16; i++) m_gfx[i] = 8'h00;
        for (int i = 0; i < 32; i++) m_crt[i] = 8'h00;
        m_si = 0; m_gi = 0; m_ci = 0; m_misc = 0;
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        case (a)
            16'h03C4: m_si = d & 8'h07;
            16'h03CE: m_gi = d & 8'h0F;
            16'h03D4: m_ci = d & 8'h1F;
            16'h03C5: if (m_si < SEQ_N) m_seq[m_si] = d;
            16'h03CF: if (m_gi < GFX_N) m_gfx[m_gi] = d;
            16'h03D5: if (m_ci < CRT_N) begin
                if (m_crt[17][7] && m_ci < 7) ;
                else if (m_crt[17][7] && m_ci == 7)
                    m_crt[7] = (m_crt[7] & 8'hEF) | (d & 8'h10);
                else m_crt[m_ci] = d;
            end
            16'h03C2: m_misc = d;
            default: ;
        endcase
    endtask

    function automatic logic [7:0] model_read(input logic [15:0] a);
        case (a)
            16'h03C4: return m_si;
            16'h03CE: return m_gi;
            16'h03D4: return m_ci;
            16'h03C5: return (m_si < SEQ_N) ? m_seq[m_si] : 8'h00;
            16'h03CF: return (m_gi < GFX_N) ? m_gfx[m_gi] : 8'h00;
            16'h03D5: return (m_ci < CRT_N) ? m_crt[m_ci] : 8'h00;
            16'h03C2: return status_in;
            16'h03CC: return m_misc;
            default:  return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
        model_write(a, d);
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input string tag);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1; io_wr = 1'b0;
        #1;
        check(tag, io_rdata, model_read(a));
        io_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    localparam logic [15:0] PORTS [12] = '{16'h03C4, 16'h03C5, 16'h03CE, 16'h03CF,
        16'h03D4, 16'h03D5, 16'h03C2, 16'h03CC, 16'h03D5, 16'h03C5, 16'h03DA, 16'h03C3};

    initial begin
        void'($urandom(32'd7));
        io_addr = 0; io_wr = 0; io_rd = 0; io_wdata = 0; status_in = 8'h5A;
        rst = 1'b1;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R8: everything cleared
        rd(16'h03D4, "R8 crt index");
        rd(16'h03C5, "R8 seq data");
        rd(16'h03CC, "R8 misc");

        // R1/R2: round trips in each group
        wr(16'h03C4, 8'h03); wr(16'h03C5, 8'hA1);
        wr(16'h03CE, 8'h08); wr(16'h03CF, 8'hB2);
        wr(16'h03D4, 8'h18); wr(16'h03D5, 8'hC3);
        rd(16'h03C5, "R1 seq data");
        rd(16'h03CF, "R1 gfx data");
        rd(16'h03D5, "R1 crt data");
        rd(16'h03CE, "R2 gfx index");
        wr(16'h03C4, 8'hFB);
        rd(16'h03C4, "R2 upper index bits dropped");

        // R5: unimplemented sequencer index 7 and crt 1Fh
        wr(16'h03C4, 8'h07); wr(16'h03C5, 8'hEE);
        rd(16'h03C5, "R5 unimplemented read zero");
        wr(16'h03D4, 8'h1F); wr(16'h03D5, 8'h77);
        rd(16'h03D5, "R5 crt unimplemented");

        // R3/R4/R10: misc register
        wr(16'h03C2, 8'h67);
        rd(16'h03CC, "R3 misc read port");
        rd(16'h03C2, "R4 status at misc write port");
        check("R10 misc_out", misc_out, 8'h67);
        wr(16'h03CC, 8'h11);
        rd(16'h03CC, "R3 write to read port ignored");

        // R6/R7: protection
        wr(16'h03D4, 8'h02); wr(16'h03D5, 8'h44);
        wr(16'h03D4, 8'h07); wr(16'h03D5, 8'hFF);
        wr(16'h03D4, 8'h11); wr(16'h03D5, 8'h80);
        wr(16'h03D4, 8'h02); wr(16'h03D5, 8'h99);
        rd(16'h03D5, "R6 protected write blocked");
        wr(16'h03D4, 8'h07); wr(16'h03D5, 8'h00);
        rd(16'h03D5, "R6 index 07h only bit 4 changes");
        wr(16'h03D4, 8'h11); wr(16'h03D5, 8'h00);
        rd(16'h03D5, "R7 protect register writable");
        wr(16'h03D4, 8'h02); wr(16'h03D5, 8'h99);
        rd(16'h03D5, "R7 protection lifted");

        // R9: idle and unmapped
        @(negedge clk); io_addr = 16'h03D5; #1;
        check("R9 rdata idle", io_rdata, 8'h00);
        wr(16'h03DA, 8'hFF);
        rd(16'h03DA, "R9 unmapped read");
        rd(16'h03D5, "R9 unmapped write no effect");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] a;
            a = PORTS[$urandom_range(11)];
            if ($urandom_range(15) == 0) a = 16'($urandom);
            status_in = 8'($urandom);
            if ($urandom_range(1)) wr(a, 8'($urandom));
            else rd(a, "R1 R2 R5 R6 random");
            if (n % 200 == 0) check("R10 misc_out random", misc_out, m_misc);
        end

        // R8: mid-run reset
        @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
        model_reset();
        rd(16'h03CF, "R8 after reset");
        rd(16'h03D4, "R8 crt index after reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule